// File: doc/BRIEF.md
# Blind Oversampling Data Picker

This block recovers an NRZ bit stream from samples taken at three times the bit rate by a clock that runs free of the data. Every clock cycle it takes one word of consecutive samples. The default word is twelve samples, or four bit cells. It compares each sample with the one before it to find where the data changes. It counts those changes by their position within a bit cell, and it takes the busiest position as the cell boundary. The recovered bit is the sample in the middle of each cell.

When a word has no transitions, the last known phase is held. That bridges long runs of equal bits. The chosen phase can move by at most one sample per word. A move across the word boundary takes up or gives back one bit. The block then delivers three or five bits instead of four, and a count output says how many bits are valid. A mode input replaces the single centre sample with a majority vote over the whole bit cell. A downstream elastic buffer absorbs the varying bit count.

Top module: `oversample_picker`

## Requirements
- R1: A synchronous reset (`rst` high) clears `bitsOut` and `bitCount` to zero. It clears the sample history to zeros and sets the centre phase to 1.
- R2: `samplesIn[0]` is the earliest sample. The word on the input at clock edge k is delivered at clock edge k+1. It is delivered together with the word then on the input. In the normal case `bitCount` is 4 and `bitsOut[j]` (j = 0..3, earliest bit in bit 0) is sample 3*j + c, where c is the updated centre phase.
- R3: A transition at sample position i (0..11) is counted when sample i differs from sample i-1. For i = 0 the comparison is with the last sample of the previous word. The transition counts toward phase i mod 3.
- R4: The boundary phase is the phase with the most transitions in the word. On a tie, the current boundary (centre minus 1, mod 3) is kept if it is among the tied phases. Otherwise the lowest tied phase is taken. The target centre is the boundary plus 1 (mod 3). The centre moves at most one position per word, in the shorter circular direction.
- R5: A word with no transitions leaves the centre phase unchanged.
- R6: When the centre moves from 2 to 0, `bitCount` is 3 and the bits are samples 3, 6 and 9.
- R7: When the centre moves from 0 to 2, `bitCount` is 5. `bitsOut[0]` is the last sample of the previous word, followed by samples 2, 5, 8 and 11.
- R8: With `voteMode` high, each bit is the majority of the three samples centred on its centre sample. The window may reach into the previous or the next word. With `voteMode` low, each bit is the centre sample alone.
- R9: Bits of `bitsOut` at positions `bitCount` and above are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-word clock |
| rst | input | 1 | Synchronous reset, active high |
| voteMode | input | 1 | 1 = majority vote per bit, 0 = centre sample |
| samplesIn | input | 12 | Oversampled word, bit 0 earliest |
| bitsOut | output | 5 | Recovered bits, bit 0 earliest |
| bitCount | output | 3 | Number of valid bits in `bitsOut` (3, 4 or 5) |

## Verification
The tests begin with constant words, which show the reset phase and the hold on words without transitions. They then use cleanly aligned data with boundaries at each of the three phases, so each phase step and both wraps can be told apart by bit count and bit position. A word whose only transition sits across the word boundary, and a word with tied phase counts, separate the edge and tie rules. A word with one flipped centre sample, sent in both modes, contrasts centre picking with voting. Pseudo-random words then mix all cases against the bench's own model.

// File: rtl/bos_pkg.sv
package bos_pkg;
  // strobes from the phase control to the picking datapath
  typedef struct packed {
    logic wrapFwd;   // centre moved from last phase to phase 0
    logic wrapBack;  // centre moved from phase 0 to last phase
  } pickStrobe_t;
endpackage

// File: rtl/bos_datapath.sv
module bos_datapath
  import bos_pkg::*;
#(
  parameter int OSR  = 3,
  parameter int BITS = 4,
  localparam int W   = OSR * BITS,
  localparam int H   = (OSR - 1) / 2,
  localparam int CW  = $clog2(BITS + 1),
  localparam int PW  = $clog2(OSR),
  localparam int NW  = $clog2(BITS + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                voteMode,
  input  logic [W-1:0]        samplesIn,
  input  logic [PW-1:0]       centreNext,
  input  pickStrobe_t         strobe,
  output logic [OSR*CW-1:0]   edgeCounts,
  output logic [BITS:0]       bitsOut,
  output logic [NW-1:0]       bitCount
);
  localparam int EL = W + 2 * H + 1;

  logic [W-1:0]  curWord;
  logic [H:0]    tailReg;
  logic [EL-1:0] ext;
  logic [W-1:0]  edgeBit;
  logic          outLive;

  // ext[0] is the oldest sample: tail of the word before, current word, lookahead
  assign ext = {samplesIn[H-1:0], curWord, tailReg};

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign edgeBit[i] = ext[i+H+1] ^ ext[i+H];
  end

  for (genvar p = 0; p < OSR; p++) begin : g_phase
    logic [BITS-1:0] phaseEdges;
    for (genvar k = 0; k < BITS; k++) begin : g_bit
      assign phaseEdges[k] = edgeBit[k*OSR+p];
    end
    assign edgeCounts[p*CW +: CW] = CW'($countones(phaseEdges));
  end

  // candidate bit m sits at sample (m-1)*OSR + centre; m = 0 reaches into the previous word
  logic [BITS:0][OSR-1:0] candCentre, candVote;
  for (genvar m = 0; m <= BITS; m++) begin : g_cand
    for (genvar c = 0; c < OSR; c++) begin : g_ctr
      localparam int E = (m - 1) * OSR + c + H + 1;
      if (E - H >= 0) begin : g_ok
        assign candCentre[m][c] = ext[E];
        assign candVote[m][c]   = ($countones(ext[E-H +: 2*H+1]) > H);
      end else begin : g_none
        assign candCentre[m][c] = 1'b0;
        assign candVote[m][c]   = 1'b0;
      end
    end
  end

  logic [BITS:0]   cand, bitsNext;
  logic [NW-1:0]   countNext;

  always_comb begin
    for (int m = 0; m <= BITS; m++) begin
      cand[m] = voteMode ? candVote[m][centreNext] : candCentre[m][centreNext];
    end
    if (strobe.wrapBack) begin
      bitsNext  = cand;
      countNext = NW'(BITS + 1);
    end else if (strobe.wrapFwd) begin
      bitsNext  = cand >> 2;
      countNext = NW'(BITS - 1);
    end else begin
      bitsNext  = cand >> 1;
      countNext = NW'(BITS);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curWord  <= '0;
      tailReg  <= '0;
      bitsOut  <= '0;
      bitCount <= '0;
      outLive  <= 1'b0;
    end else begin
      curWord  <= samplesIn;
      tailReg  <= curWord[W-1 -: H+1];
      bitsOut  <= bitsNext;
      bitCount <= countNext;
      outLive  <= 1'b1;
    end
  end

  AST_WRAP_BACK_COUNT: assert property (@(posedge clk) disable iff (rst)
    strobe.wrapBack |=> (bitCount == NW'(BITS + 1))); // R7
  AST_WRAP_FWD_COUNT: assert property (@(posedge clk) disable iff (rst)
    strobe.wrapFwd |=> (bitCount == NW'(BITS - 1))); // R6
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    outLive |-> (bitCount >= NW'(BITS - 1) && bitCount <= NW'(BITS + 1))); // R2
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    outLive |-> ((bitsOut >> bitCount) == '0)); // R9
endmodule

// File: rtl/bos_control.sv
module bos_control
  import bos_pkg::*;
#(
  parameter int OSR  = 3,
  parameter int BITS = 4,
  localparam int H   = (OSR - 1) / 2,
  localparam int CW  = $clog2(BITS + 1),
  localparam int PW  = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OSR*CW-1:0] edgeCounts,
  output logic [PW-1:0]     centreNext,
  output pickStrobe_t       strobe
);
  logic [PW-1:0] centre;
  logic [CW-1:0] maxVal;
  logic          anyEdge, boundIsMax;
  int            cNow, boundNow, tgt, tgtCentre, diff, cNew;

  always_comb begin
    anyEdge = |edgeCounts;
    maxVal  = '0;
    for (int p = 0; p < OSR; p++) begin
      if (edgeCounts[p*CW +: CW] > maxVal) maxVal = edgeCounts[p*CW +: CW];
    end
    cNow     = int'(centre);
    boundNow = (cNow >= H) ? cNow - H : cNow + OSR - H;
    boundIsMax = 1'b0;
    for (int p = 0; p < OSR; p++) begin
      if (p == boundNow && edgeCounts[p*CW +: CW] == maxVal) boundIsMax = 1'b1;
    end
    tgt = boundNow;
    if (!boundIsMax) begin
      for (int p = OSR - 1; p >= 0; p--) begin
        if (edgeCounts[p*CW +: CW] == maxVal) tgt = p;
      end
    end
    tgtCentre = (tgt + H >= OSR) ? tgt + H - OSR : tgt + H;
    diff      = (tgtCentre >= cNow) ? tgtCentre - cNow : tgtCentre + OSR - cNow;
    if (!anyEdge || diff == 0) cNew = cNow;
    else if (diff <= H)        cNew = (cNow == OSR - 1) ? 0 : cNow + 1;
    else                       cNew = (cNow == 0) ? OSR - 1 : cNow - 1;
    centreNext      = PW'(cNew);
    strobe.wrapFwd  = (cNow == OSR - 1) && (cNew == 0);
    strobe.wrapBack = (cNow == 0) && (cNew == OSR - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) centre <= PW'(H);
    else     centre <= centreNext;
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (edgeCounts == '0) |=> $stable(centre)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (centre == $past(centre)
           || centre == (($past(centre) == PW'(OSR - 1)) ? '0 : $past(centre) + 1'b1)
           || centre == (($past(centre) == '0) ? PW'(OSR - 1) : $past(centre) - 1'b1))); // R4
endmodule

// File: rtl/oversample_picker.sv
module oversample_picker
  import bos_pkg::*;
#(
  parameter int OSR  = 3,
  parameter int BITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        voteMode,
  input  logic [OSR*BITS-1:0]         samplesIn,
  output logic [BITS:0]               bitsOut,
  output logic [$clog2(BITS+2)-1:0]   bitCount
);
  localparam int CW = $clog2(BITS + 1);
  localparam int PW = $clog2(OSR);

  logic [OSR*CW-1:0] edgeCounts;
  logic [PW-1:0]     centreNext;
  pickStrobe_t       strobe;

  bos_control #(.OSR(OSR), .BITS(BITS)) control_i (
    .clk(clk), .rst(rst), .edgeCounts(edgeCounts),
    .centreNext(centreNext), .strobe(strobe)
  );

  bos_datapath #(.OSR(OSR), .BITS(BITS)) datapath_i (
    .clk(clk), .rst(rst), .voteMode(voteMode), .samplesIn(samplesIn),
    .centreNext(centreNext), .strobe(strobe), .edgeCounts(edgeCounts),
    .bitsOut(bitsOut), .bitCount(bitCount)
  );
endmodule

// File: tb/oversample_picker_tb_top.sv
`timescale 1ns/1ps
module oversample_picker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        voteMode = 1'b0;
  logic [11:0] samplesIn = '0;
  logic [4:0]  bitsOut;
  logic [2:0]  bitCount;

  int nTests = 0;
  int nFail  = 0;

  typedef struct {
    logic [4:0] bits;
    logic [2:0] cnt;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [11:0] prev1 = '0, prev2 = '0;
  int          mCentre = 1;

  always #2 clk = ~clk;

  oversample_picker dut_i (
    .clk(clk), .rst(rst), .voteMode(voteMode), .samplesIn(samplesIn),
    .bitsOut(bitsOut), .bitCount(bitCount)
  );

  // bench model of one word, built from the requirements
  function automatic void modelStep(input logic [11:0] tw, input logic [11:0] cw,
                                    input logic [11:0] nw, input logic mode,
                                    inout int cen, output logic [4:0] ob,
                                    output logic [2:0] oc);
    logic ext[15];
    int   cnt[3];
    int   mx, b, t, tc, dif, nc, st, e, ones;
    logic [4:0] cand;
    ext[0] = tw[10]; ext[1] = tw[11]; ext[14] = nw[0];
    for (int i = 0; i < 12; i++) ext[i+2] = cw[i];
    for (int p = 0; p < 3; p++) cnt[p] = 0;
    for (int i = 0; i < 12; i++) if (ext[i+2] != ext[i+1]) cnt[i%3]++;
    nc = cen;
    if (cnt[0] + cnt[1] + cnt[2] > 0) begin
      mx = cnt[0];
      if (cnt[1] > mx) mx = cnt[1];
      if (cnt[2] > mx) mx = cnt[2];
      b = (cen + 2) % 3;
      if (cnt[b] == mx) t = b;
      else if (cnt[0] == mx) t = 0;
      else if (cnt[1] == mx) t = 1;
      else t = 2;
      tc  = (t + 1) % 3;
      dif = (tc - cen + 3) % 3;
      if (dif == 1) nc = (cen + 1) % 3;
      else if (dif == 2) nc = (cen + 2) % 3;
    end
    for (int m = 0; m < 5; m++) begin
      e = (m - 1) * 3 + nc + 2;
      if (e - 1 < 0) cand[m] = 1'b0;
      else if (mode) begin
        ones = int'(ext[e-1]) + int'(ext[e]) + int'(ext[e+1]);
        cand[m] = (ones >= 2);
      end else cand[m] = ext[e];
    end
    if (cen == 2 && nc == 0) st = 2;
    else if (cen == 0 && nc == 2) st = 0;
    else st = 1;
    ob  = cand >> st;
    oc  = 3'(5 - st);
    cen = nc;
  endfunction

  // word of four aligned bit cells whose first boundary is at sample off
  function automatic logic [11:0] mk(input logic [3:0] bv, input int off, input logic carry);
    logic [11:0] w;
    for (int i = 0; i < 12; i++) begin
      if (i - off < 0) w[i] = carry;
      else w[i] = bv[(i - off) / 3];
    end
    return w;
  endfunction

  // driver: the expected result for the word now held in the design is pushed
  // as the following word is driven
  task automatic sendWord(input logic [11:0] w, input logic mode, input string tag);
    expItem_t it;
    @(negedge clk);
    modelStep(prev2, prev1, w, mode, mCentre, it.bits, it.cnt);
    it.tag = tag;
    expQ.push_back(it);
    samplesIn = w;
    voteMode  = mode;
    prev2 = prev1;
    prev1 = w;
  endtask

  // monitor
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        nTests++;
        if (bitsOut !== it.bits || bitCount !== it.cnt) begin
          nFail++;
          $display("FAIL %s: actual bits=%b count=%0d expected bits=%b count=%0d",
                   it.tag, bitsOut, bitCount, it.bits, it.cnt);
        end
      end
    end
  end

  initial begin
    #400000;
    nFail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [11:0] w;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    nTests++;
    if (bitsOut !== 5'd0 || bitCount !== 3'd0) begin
      nFail++;
      $display("FAIL R1 reset: actual bits=%b count=%0d expected bits=00000 count=0",
               bitsOut, bitCount);
    end
    rst = 1'b0;
    sendWord(12'h000, 1'b0, "R1 R5 reset word, centre 1");
    sendWord(12'h000, 1'b0, "R5 constant word");
    sendWord(mk(4'b1101, 0, 1'b0), 1'b0, "R2 aligned boundary 0");
    sendWord(mk(4'b0010, 0, 1'b1), 1'b0, "R2 R3 pattern two");
    sendWord({12{~prev1[11]}}, 1'b0, "R3 only edge across word boundary");
    sendWord(mk(4'b1010, 1, 1'b0), 1'b0, "R4 boundary 1 step to centre 2");
    sendWord(mk(4'b0110, 1, 1'b0), 1'b0, "R4 hold centre 2");
    sendWord(mk(4'b1001, 2, 1'b1), 1'b0, "R6 wrap 2 to 0, three bits");
    sendWord(mk(4'b0110, 2, 1'b1), 1'b0, "R2 centre 0");
    sendWord({12{prev1[11]}}, 1'b0, "R5 no edges hold 0");
    sendWord({12{prev1[11]}}, 1'b0, "R5 no edges hold 0 again");
    sendWord(mk(4'b1010, 1, ~prev1[11]), 1'b0, "R7 wrap 0 to 2, five bits");
    sendWord(mk(4'b0101, 1, 1'b0), 1'b0, "R2 centre 2");
    w = {12{prev1[11]}};
    w[1] = ~prev1[11];
    w[2] = ~prev1[11];
    sendWord(w, 1'b0, "R4 tie keeps current boundary");
    w = mk(4'b0101, 0, 1'b0);
    w[4] = 1'b1;
    sendWord(w, 1'b1, "R8 vote masks flipped centre sample");
    sendWord(w, 1'b0, "R8 centre mode shows flipped sample");
    sendWord(w, 1'b1, "R8 vote again");
    sendWord(12'h000, 1'b0, "R9 settle");
    lfsr = 16'hACE1;
    for (int n = 0; n < 60; n++) begin
      for (int s = 0; s < 12; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n % 3 == 0) w = mk(lfsr[3:0], lfsr[5:4] % 3, prev1[11]);
      else w = lfsr[11:0];
      sendWord(w, lfsr[7], "R2 R4 R6 R7 R8 R9 mixed word");
    end
    sendWord(12'h000, 1'b0, "R9 flush");
    sendWord(12'h000, 1'b0, "R9 flush");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule